// File: doc/BRIEF.md
# Beacon Timer Unit

This block keeps a 64-bit timing-synchronisation counter (TSF) in microseconds and four programmable event timers. Each timer is compared against the TSF and raises a one-cycle pulse when they match: the next target beacon time, an early alert for the beacon DMA, an early alert for software, and the end of the ATIM window. Two timers count in whole time units (1 TU = 1024 TSF ticks). The two alert timers count in eighths of a TU, so they can be placed a fraction of a TU ahead of the beacon.

Software loads the four timers first. It then writes the control word, which holds the beacon period, the enable bit and the TSF-reset bit. While beaconing is enabled, every timer that fires moves itself forward by one beacon period, counted in its own resolution. The TSF-reset bit works as a toggle: a write with the bit set flips an internal line, and the TSF clears only when that line goes high. Software therefore writes the bit twice, so the line ends low. A read port returns the two halves of the TSF and the next beacon time, converted to TSF ticks.

Top module: `beacon_timer_unit`

## Requirements
- R1: After reset, the TSF is 0, the beacon period is 0, beaconing is disabled, timers 0 to 2 are 0, timer 3 is 1, and all pulses are low. The TSF increases by exactly one on each clock edge where tick_us is high. It holds its value when tick_us is low.
- R2: Timer 0 is written at wr_addr 0 and keeps wr_data[15:0] as a count of TUs. Its pulse tbtt_pulse is high while the TSF equals the stored value times 1024.
- R3: Timer 1 is written at wr_addr 1 and keeps wr_data[18:0]. Timer 2 is written at wr_addr 2 and keeps wr_data[24:0]. Both count in eighths of a TU. Their pulses dba_pulse and swba_pulse are high while the TSF equals the stored value times 128. Higher data bits are dropped.
- R4: Timer 3 is written at wr_addr 3 and keeps wr_data[15:0] in TUs. A write of 0 is stored as 1. Its pulse atim_pulse is high while the TSF equals the stored value times 1024.
- R5: When a timer fires while beaconing is enabled, the timer advances on the next edge. Timers 0 and 3 advance by the period in TUs. Timers 1 and 2 advance by the period times 8 in eighths. Each match therefore gives a single-cycle pulse, and the pulses repeat every period × 1024 TSF ticks.
- R6: The control word is written at wr_addr 4. The beacon period in TUs is in [15:0], the enable bit is bit 16, and the TSF-reset bit is bit 31. While enable is 0, no pulse is raised and no timer advances. The TSF keeps counting.
- R7: Each control write with bit 31 set flips the internal reset line. The TSF becomes 0 on the edge where that line goes from 0 to 1. The write that returns the line to 0 leaves the TSF counting.
- R8: rd_data is combinational from rd_addr. Address 0 returns TSF[31:0]. Address 1 returns TSF[63:32]. Address 2 returns timer 0 times 1024. Address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-microsecond tick enable for the TSF |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0-3 timers, 4 control) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data |
| tbtt_pulse | output | 1 | Next-beacon-time pulse (timer 0) |
| dba_pulse | output | 1 | Beacon DMA alert pulse (timer 1) |
| swba_pulse | output | 1 | Software beacon alert pulse (timer 2) |
| atim_pulse | output | 1 | ATIM window pulse (timer 3) |

## Verification
The single-pulse property assumes two things about the inputs. The beacon period is nonzero while beaconing is enabled, and software does not rewrite a timer in the cycle right after it fired. The hold property excuses only the edge where a TSF-reset write lands. The stimulus keeps to these assumptions. It draws random periods of 2 to 4 TU, and it writes timers only with beaconing off or with every expiry well ahead of the TSF. It then runs the TSF with randomly gated ticks and checks the TSF value at every pulse against the expected schedule for that timer.

// File: rtl/beacon_timer_unit.sv
module beacon_timer_unit #(
  parameter int TSF_W     = 64,
  parameter int TU_W      = 16,
  parameter int DBA_W     = 19,
  parameter int SBA_W     = 25,
  parameter int TU_SHIFT  = 10,
  parameter int SUB_SHIFT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_us,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        tbtt_pulse,
  output logic        dba_pulse,
  output logic        swba_pulse,
  output logic        atim_pulse
);
  localparam int FINE_SHIFT = TU_SHIFT - SUB_SHIFT;
  localparam logic [2:0] A_T0 = 3'd0, A_T1 = 3'd1, A_T2 = 3'd2, A_T3 = 3'd3, A_CTL = 3'd4;
  localparam int EN_BIT  = 16;
  localparam int TGL_BIT = 31;

  logic [TSF_W-1:0] tsf_q;
  logic [TU_W-1:0]  t0_q, t3_q, period_q;
  logic [DBA_W-1:0] t1_q;
  logic [SBA_W-1:0] t2_q;
  logic             en_q, tgl_q;

  logic wr_ctl, tgl_flip, tsf_clr;
  logic [TSF_W-1:0] exp0, exp1, exp2, exp3;
  logic unused_wr;

  assign wr_ctl   = wr_en && (wr_addr == A_CTL);
  assign tgl_flip = wr_ctl && wr_data[TGL_BIT];
  assign tsf_clr  = tgl_flip && !tgl_q;
  assign unused_wr = ^wr_data[30:SBA_W];

  assign exp0 = TSF_W'({t0_q, {TU_SHIFT{1'b0}}});
  assign exp3 = TSF_W'({t3_q, {TU_SHIFT{1'b0}}});
  assign exp1 = TSF_W'({t1_q, {FINE_SHIFT{1'b0}}});
  assign exp2 = TSF_W'({t2_q, {FINE_SHIFT{1'b0}}});

  assign tbtt_pulse = en_q && (tsf_q == exp0);
  assign dba_pulse  = en_q && (tsf_q == exp1);
  assign swba_pulse = en_q && (tsf_q == exp2);
  assign atim_pulse = en_q && (tsf_q == exp3);

  always_ff @(posedge clk) begin
    if (!rst_n)       tsf_q <= '0;
    else if (tsf_clr) tsf_q <= '0;
    else if (tick_us) tsf_q <= tsf_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgl_q    <= 1'b0;
      en_q     <= 1'b0;
      period_q <= '0;
    end else if (wr_ctl) begin
      tgl_q    <= tgl_q ^ wr_data[TGL_BIT];
      en_q     <= wr_data[EN_BIT];
      period_q <= wr_data[TU_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         t0_q <= '0;
    else if (wr_en && wr_addr == A_T0)  t0_q <= wr_data[TU_W-1:0];
    else if (tbtt_pulse)                t0_q <= t0_q + period_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         t1_q <= '0;
    else if (wr_en && wr_addr == A_T1)  t1_q <= wr_data[DBA_W-1:0];
    else if (dba_pulse)                 t1_q <= t1_q + DBA_W'({period_q, {SUB_SHIFT{1'b0}}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         t2_q <= '0;
    else if (wr_en && wr_addr == A_T2)  t2_q <= wr_data[SBA_W-1:0];
    else if (swba_pulse)                t2_q <= t2_q + SBA_W'({period_q, {SUB_SHIFT{1'b0}}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         t3_q <= TU_W'(1);
    else if (wr_en && wr_addr == A_T3)  t3_q <= (wr_data[TU_W-1:0] == '0) ? TU_W'(1) : wr_data[TU_W-1:0];
    else if (atim_pulse)                t3_q <= t3_q + period_q;
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = tsf_q[31:0];
      2'd1:    rd_data = 32'(tsf_q >> 32);
      2'd2:    rd_data = 32'(exp0);
      default: rd_data = '0;
    endcase
  end
endmodule

module beacon_timer_unit_chk #(
  parameter int TSF_W = 64,
  parameter int TU_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_us,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic             wr_tgl,
  input logic             en_q,
  input logic             tgl_q,
  input logic [TSF_W-1:0] tsf_q,
  input logic [TU_W-1:0]  t0_q,
  input logic [TU_W-1:0]  t3_q,
  input logic [TU_W-1:0]  period_q,
  input logic [3:0]       pulses
);
  logic ctl_tgl;
  assign ctl_tgl = wr_en && (wr_addr == 3'd4) && wr_tgl;

  // R1
  tsf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_us && !ctl_tgl) |=> $stable(tsf_q));

  // R7
  tsf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgl_q) |-> (tsf_q == '0));

  // R6
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (pulses == 4'b0000));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pulses != 4'b0000) && period_q != '0 && !wr_en) |=> ((pulses & $past(pulses)) == 4'b0000));

  // R5
  tbtt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulses[0] && !(wr_en && wr_addr == 3'd0)) |=> (t0_q == $past(t0_q + period_q)));

  // R4
  atim_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t3_q != '0);
endmodule

bind beacon_timer_unit beacon_timer_unit_chk #(.TSF_W(TSF_W), .TU_W(TU_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_tgl(wr_data[31]), .en_q(en_q), .tgl_q(tgl_q), .tsf_q(tsf_q), .t0_q(t0_q),
  .t3_q(t3_q), .period_q(period_q),
  .pulses({atim_pulse, swba_pulse, dba_pulse, tbtt_pulse})
);

// File: tb/beacon_timer_unit_tb.sv
module beacon_timer_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic tbtt_pulse, dba_pulse, swba_pulse, atim_pulse;

  int checks = 0;
  int fails = 0;
  longint next_t [4];
  longint per_t [4];
  int cnt [4];
  bit done = 0;

  always #4 clk = ~clk;

  beacon_timer_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tbtt_pulse(tbtt_pulse),
    .dba_pulse(dba_pulse), .swba_pulse(swba_pulse), .atim_pulse(atim_pulse)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(bit tgl, bit en, int per);
    return {tgl, 14'd0, en, per[15:0]};
  endfunction

  function automatic int hits(longint base, longint per, longint last);
    if (last < base) return 0;
    return int'((last - base) / per) + 1;
  endfunction

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    #1 v = rd_data;
    rd_addr = 2'd0;
  endtask

  task automatic run_until(longint last, bit randtick, string req);
    logic [3:0] p;
    longint t;
    for (int i = 0; i < 4; i++) cnt[i] = 0;
    rd_addr = 2'd0;
    forever begin
      @(negedge clk);
      t = longint'(rd_data);
      p = {atim_pulse, swba_pulse, dba_pulse, tbtt_pulse};
      for (int i = 0; i < 4; i++) begin
        if (p[i]) begin
          chk(t == next_t[i], req, t, next_t[i]);
          next_t[i] += per_t[i];
          cnt[i]++;
        end
      end
      tick_us = randtick ? ($urandom % 3 != 0) : 1'b1;
      if (t >= last) break;
    end
  endtask

  task automatic tsf_restart();
    wr(3'd4, ctl(1, 0, 0));
    wr(3'd4, ctl(1, 0, 0));
  endtask

  initial begin
    logic [31:0] v, v2;
    int t0, per, d1, d2;
    longint last;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1 reset tsf", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 reset timer0", v, 0);
    chk({atim_pulse, swba_pulse, dba_pulse, tbtt_pulse} == 0, "R1 reset pulses",
        {atim_pulse, swba_pulse, dba_pulse, tbtt_pulse}, 0);

    // R1 tick gating
    tick_us = 1'b0;
    rd(2'd0, v);
    repeat (20) @(negedge clk);
    rd(2'd0, v2); chk(v2 == v, "R1 hold", v2, v);
    tick_us = 1'b1;
    repeat (30) @(negedge clk);
    rd(2'd0, v2); chk(v2 == v + 30, "R1 count", v2, v + 30);

    // R2 R3 R4 directed: truncation and zero ATIM
    tsf_restart();
    wr(3'd0, 32'h0001_0003);
    wr(3'd1, 32'h0008_0014);
    wr(3'd2, 32'h0200_001E);
    wr(3'd3, 32'h0000_0000);
    wr(3'd4, ctl(0, 1, 100));
    next_t[0] = 3072; next_t[1] = 2560; next_t[2] = 3840; next_t[3] = 1024;
    for (int i = 0; i < 4; i++) per_t[i] = 102400;
    run_until(4000, 1, "R2 R3 R4 directed");
    chk(cnt[0] == 1, "R2 timer0 count", cnt[0], 1);
    chk(cnt[1] == 1, "R3 timer1 count", cnt[1], 1);
    chk(cnt[2] == 1, "R3 timer2 count", cnt[2], 1);
    chk(cnt[3] == 1, "R4 zero atim count", cnt[3], 1);

    // R5 random rounds
    for (int r = 0; r < 3; r++) begin
      t0 = 2 + int'($urandom % 4);
      per = 2 + int'($urandom % 3);
      d1 = 1 + int'($urandom % 6);
      d2 = 1 + int'($urandom % 12);
      wr(3'd4, ctl(0, 0, per));
      tsf_restart();
      wr(3'd0, 32'(t0));
      wr(3'd1, 32'(t0 * 8 - d1));
      wr(3'd2, 32'(t0 * 8 - d2));
      wr(3'd3, 32'(t0 + 1));
      wr(3'd4, ctl(0, 1, per));
      next_t[0] = longint'(t0) * 1024;
      next_t[1] = longint'(t0 * 8 - d1) * 128;
      next_t[2] = longint'(t0 * 8 - d2) * 128;
      next_t[3] = longint'(t0 + 1) * 1024;
      for (int i = 0; i < 4; i++) per_t[i] = longint'(per) * 1024;
      last = next_t[3] + 2 * per_t[3] + 10;
      run_until(last, 1, "R5 schedule");
      chk(cnt[0] == hits(longint'(t0) * 1024, per_t[0], last), "R5 tbtt count",
          cnt[0], hits(longint'(t0) * 1024, per_t[0], last));
      chk(cnt[1] == hits(longint'(t0 * 8 - d1) * 128, per_t[1], last), "R5 dba count",
          cnt[1], hits(longint'(t0 * 8 - d1) * 128, per_t[1], last));
      chk(cnt[2] == hits(longint'(t0 * 8 - d2) * 128, per_t[2], last), "R5 swba count",
          cnt[2], hits(longint'(t0 * 8 - d2) * 128, per_t[2], last));
      chk(cnt[3] == 3, "R5 atim count", cnt[3], 3);
      rd(2'd2, v);
      chk(longint'(v) == next_t[0], "R8 next beacon readback", v, next_t[0]);
    end

    // R6 disabled: no pulses, no reload, TSF counts
    wr(3'd4, ctl(0, 0, per));
    rd(2'd2, v);
    rd(2'd0, v2);
    last = longint'(v2) + 5000;
    for (int i = 0; i < 4; i++) next_t[i] = -1;
    run_until(last, 0, "R6 pulse while off");
    chk(cnt[0] + cnt[1] + cnt[2] + cnt[3] == 0, "R6 pulses off",
        cnt[0] + cnt[1] + cnt[2] + cnt[3], 0);
    rd(2'd2, v2); chk(v2 == v, "R6 no reload", v2, v);
    rd(2'd0, v2); chk(longint'(v2) >= last, "R6 tsf counts", v2, last);

    // R8 upper half and unused address
    rd(2'd1, v); chk(v == 0, "R8 tsf high", v, 0);
    rd(2'd3, v); chk(v == 0, "R8 addr3", v, 0);

    // R7 toggle rise clears, fall does not
    tick_us = 1'b1;
    wr(3'd4, ctl(1, 0, 0));
    rd(2'd0, v); chk(v == 0, "R7 clear on rise", v, 0);
    repeat (50) @(negedge clk);
    wr(3'd4, ctl(1, 0, 0));
    rd(2'd0, v); chk(v == 52, "R7 no clear on fall", v, 52);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule